// File: doc/BRIEF.md
# Bus-Attached Serial Port with Flow Control and Interrupts

This block is an asynchronous serial transmitter and receiver that a processor reaches through two word addresses on a simple register bus. Writes to the lower address set up the port: the bit rate, the request-to-send output and two interrupt enables. Reads from the same address return a status byte. The upper address carries character data. A write there queues one character for transmission, and a read there returns the last character received.

The transmitter keeps one holding register ahead of its shift register. It moves a character from the holding register into the shifter only while the clear-to-send input is high. The receiver detects a falling start edge, checks it again at mid-bit and then samples every later bit at its centre. Completed characters go into a single receive buffer. The port tracks framing errors and overruns. Each of the two data-path events (holding register emptied, receive buffer filled) has its own pending flag, and an enable bit masks each flag onto a single interrupt line.

Top module: `serial_port`

## Requirements
- R1: After reset the status byte reads 0xC0 when CTS is high, or 0x40 when CTS is low. The serial output idles high, and RTS and the interrupt line are low.
- R2: Address 0 is the control register on a write and returns status on a read. Address 1 is TX data on a write and RX data on a read. Read data appears on bus_rdata one cycle after the read strobe, with bits 31..8 zero. Write bits 31..8 are ignored.
- R3: The RTS output follows control bit 7.
- R4: Control bits 2..0 select a bit period of 2^(code+2) clock cycles, so code 0 gives 4 cycles and code 5 gives 128. Codes 6 and 7 both give 256 cycles.
- R5: A frame is one low start bit, then eight data bits least significant bit first, then one high stop bit. The line is high between frames.
- R6: While CTS is low, a queued character stays in the holding register and the serial output stays high. Status bit 7 shows the synchronised CTS level.
- R7: A TX data write clears status bit 6 (holding register empty) and status bit 4 (TX pending). When the character moves into the shifter, both bits are set.
- R8: When a character completes, it is stored, and status bit 5 (RX full) and status bit 3 (RX pending) are set. Reading address 1 returns the character and clears both bits.
- R9: A character whose stop bit samples low sets status bit 1 (framing error). The character is still stored.
- R10: A character that completes while RX full is set sets status bit 0 (overrun). The buffer then holds the newer character.
- R11: A status read clears bits 1 and 0, unless a new error arrives in the same cycle.
- R12: The irq output is registered. It equals (bit 4 AND control bit 4) OR (bit 3 AND control bit 3), lagging the flags by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier |
| bus_addr | input | 1 | Word address: 0 control/status, 1 data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ser_txd | output | 1 | Serial output line |
| ser_rxd | input | 1 | Serial input line |
| rts_o | output | 1 | Request-to-send output |
| cts_i | input | 1 | Clear-to-send input |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch properties that hold on every cycle. The line stays high whenever the transmitter is idle, and the bit counters stay within a frame. A TX write always leaves the holding register full, and an RX read with no completion in that cycle always clears RX full. A completion while RX full is set always raises overrun, and masked interrupts never reach irq. The bench's scenarios are needed for the rest: the bit period chosen by each speed code, the order of bits on the wire, loopback of data under several rates, holding while CTS is low, framing errors built from a hand-driven bad frame, and the clear-on-read timing of the status flags.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int CTL_RTS  = 7;
  localparam int CTL_TXIE = 4;
  localparam int CTL_RXIE = 3;
  localparam int CHAR_W   = 8;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/sp_divsel.sv
module sp_divsel #(
  parameter int CODE_W  = 3,
  parameter int LOG_MIN = 2,
  parameter int LOG_MAX = 8,
  parameter int DIV_W   = LOG_MAX + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  output logic [DIV_W-1:0]  div
);
  int sh;

  always_comb begin
    sh = int'(code) + LOG_MIN;
    if (sh > LOG_MAX) sh = LOG_MAX;
  end

  always_ff @(posedge clk) begin
    if (rst) div <= DIV_W'(1) << LOG_MIN;
    else     div <= DIV_W'(1) << sh;
  end

  // R4
  div_pow2_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(div) == 1);
endmodule

// File: rtl/sp_tx.sv
module sp_tx #(
  parameter int DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  input  logic             cts_ok,
  input  logic             have,
  input  logic [7:0]       data,
  output logic             take,
  output logic             txd
);
  logic             busy;
  logic [8:0]       sh;
  logic [3:0]       bits;
  logic [DIV_W-1:0] cnt;

  assign take = !busy && have && cts_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      txd  <= 1'b1;
      sh   <= '1;
      bits <= '0;
      cnt  <= '0;
    end else if (take) begin
      busy <= 1'b1;
      txd  <= 1'b0;
      sh   <= {1'b1, data};
      bits <= '0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == div - 1'b1) begin
        cnt <= '0;
        if (bits == 4'd9) begin
          busy <= 1'b0;
        end else begin
          txd  <= sh[0];
          sh   <= {1'b1, sh[8:1]};
          bits <= bits + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R5
  idle_line_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
  // R5
  bit_count_chk: assert property (@(posedge clk) disable iff (rst)
    bits <= 4'd9);
endmodule

// File: rtl/sp_rx.sv
module sp_rx
  import sp_pkg::*;
#(
  parameter int DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  input  logic             rxd,
  output logic             done,
  output logic [7:0]       data,
  output logic             ferr
);
  logic             r1, r2, r3;
  rx_state_t        st;
  logic [DIV_W-1:0] cnt;
  logic [2:0]       bits;
  logic [7:0]       sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      r1 <= 1'b1; r2 <= 1'b1; r3 <= 1'b1;
    end else begin
      r1 <= rxd; r2 <= r1; r3 <= r2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= RX_IDLE;
      cnt  <= '0;
      bits <= '0;
      sh   <= '0;
      done <= 1'b0;
      data <= '0;
      ferr <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        RX_IDLE: begin
          cnt <= '0;
          if (r3 && !r2) st <= RX_START;
        end
        RX_START: begin
          if (cnt == (div >> 1) - 1'b1) begin
            cnt  <= '0;
            bits <= '0;
            st   <= r2 ? RX_IDLE : RX_DATA;
          end else cnt <= cnt + 1'b1;
        end
        RX_DATA: begin
          if (cnt == div - 1'b1) begin
            cnt <= '0;
            sh  <= {r2, sh[7:1]};
            if (bits == 3'd7) st <= RX_STOP;
            else              bits <= bits + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        RX_STOP: begin
          if (cnt == div - 1'b1) begin
            cnt  <= '0;
            done <= 1'b1;
            data <= sh;
            ferr <= !r2;
            st   <= RX_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8
  done_from_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(st) == RX_STOP);
endmodule

// File: rtl/serial_port.sv
module serial_port
  import sp_pkg::*;
#(
  parameter int BUS_W   = 32,
  parameter int CODE_W  = 3,
  parameter int LOG_MIN = 2,
  parameter int LOG_MAX = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             ser_txd,
  input  logic             ser_rxd,
  output logic             rts_o,
  input  logic             cts_i,
  output logic             irq
);
  localparam int DIV_W = LOG_MAX + 1;
  localparam int PAD_W = BUS_W - CHAR_W;

  logic              txie, rxie;
  logic [CODE_W-1:0] spd;
  logic [DIV_W-1:0]  div;
  logic [7:0]        thr, rbuf, rx_byte;
  logic              tx_empty, tx_pend, rx_full, rx_pend, ferr_q, ovr_q;
  logic              c1, c2;
  logic              take, rx_done, rx_ferr;
  logic              wr_ctl, wr_tx, rd_st, rd_rx;
  logic [7:0]        status;

  assign wr_ctl = bus_sel && bus_wr && !bus_addr;
  assign wr_tx  = bus_sel && bus_wr &&  bus_addr;
  assign rd_st  = bus_sel && bus_rd && !bus_addr;
  assign rd_rx  = bus_sel && bus_rd &&  bus_addr;

  assign status = {c2, tx_empty, rx_full, tx_pend, rx_pend, 1'b0, ferr_q, ovr_q};

  sp_divsel #(.CODE_W(CODE_W), .LOG_MIN(LOG_MIN), .LOG_MAX(LOG_MAX), .DIV_W(DIV_W))
    u_div (.clk(clk), .rst(rst), .code(spd), .div(div));

  sp_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst(rst), .div(div), .cts_ok(c2), .have(!tx_empty),
    .data(thr), .take(take), .txd(ser_txd));

  sp_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst(rst), .div(div), .rxd(ser_rxd),
    .done(rx_done), .data(rx_byte), .ferr(rx_ferr));

  always_ff @(posedge clk) begin
    if (rst) begin
      rts_o <= 1'b0; txie <= 1'b0; rxie <= 1'b0; spd <= '0;
      c1 <= 1'b0; c2 <= 1'b0;
    end else begin
      c1 <= cts_i;
      c2 <= c1;
      if (wr_ctl) begin
        rts_o <= bus_wdata[CTL_RTS];
        txie  <= bus_wdata[CTL_TXIE];
        rxie  <= bus_wdata[CTL_RXIE];
        spd   <= bus_wdata[CODE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr <= '0; tx_empty <= 1'b1; tx_pend <= 1'b0;
    end else if (wr_tx) begin
      thr <= bus_wdata[7:0]; tx_empty <= 1'b0; tx_pend <= 1'b0;
    end else if (take) begin
      tx_empty <= 1'b1; tx_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rbuf <= '0; rx_full <= 1'b0; rx_pend <= 1'b0;
      ferr_q <= 1'b0; ovr_q <= 1'b0;
    end else begin
      if (rx_done) begin
        rbuf <= rx_byte; rx_full <= 1'b1; rx_pend <= 1'b1;
      end else if (rd_rx) begin
        rx_full <= 1'b0; rx_pend <= 1'b0;
      end
      if (rx_done && rx_full) ovr_q <= 1'b1;
      else if (rd_st)         ovr_q <= 1'b0;
      if (rx_done && rx_ferr) ferr_q <= 1'b1;
      else if (rd_st)         ferr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= (tx_pend && txie) || (rx_pend && rxie);
      if (bus_sel && bus_rd)
        bus_rdata <= {{PAD_W{1'b0}}, (bus_addr ? rbuf : status)};
    end
  end

  // R7
  tx_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_tx |=> !tx_empty && !tx_pend);
  // R8
  rx_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_rx && !rx_done) |=> !rx_full && !rx_pend);
  // R10
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_done && rx_full) |=> ovr_q);
  // R12
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (!txie && !rxie) |=> !irq);
  // R6
  cts_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!c2 && !tx_empty) |=> !tx_empty);
endmodule

// File: tb/sim_serial_port.sv
module sim_serial_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0, wr = 1'b0, rd = 1'b0, addr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        txd, rts, irq;
  logic        cts = 1'b1;
  logic        use_brx = 1'b0, brx = 1'b1;
  logic        rxd;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 0;

  always #4 clk = ~clk;
  assign rxd = use_brx ? brx : txd;

  serial_port u0 (
    .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr), .bus_rd(rd),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .ser_txd(txd), .ser_rxd(rxd), .rts_o(rts), .cts_i(cts), .irq(irq));

  // {speed code, character}
  localparam logic [10:0] VEC [0:5] = '{
    {3'd0, 8'h55}, {3'd1, 8'hA3}, {3'd2, 8'h00},
    {3'd0, 8'hFF}, {3'd3, 8'h81}, {3'd1, 8'h3C}};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bw(input logic a, input logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic br(input logic a, output logic [31:0] d);
    @(negedge clk); sel = 1; rd = 1; addr = a;
    @(negedge clk); sel = 0; rd = 0; d = rdata;
  endtask

  task automatic send_raw(input logic [7:0] b, input logic stopb);
    @(negedge clk); brx = 0; idle(4);
    for (int i = 0; i < 8; i++) begin brx = b[i]; idle(4); end
    brx = stopb; idle(4);
    brx = 1; idle(40);
  endtask

  initial begin
    logic [31:0] d;
    logic [2:0]  c;
    logic [9:0]  cap;
    int          w, n;
    idle(4); rst = 0; idle(5);
    br(0, d); chk("R1 status", d, 32'hC0);
    chk("R1 txd", txd, 1); chk("R1 rts", rts, 0); chk("R1 irq", irq, 0);

    bw(0, 32'hFFFF_FF80); chk("R3 rts high", rts, 1);
    bw(0, 32'h0000_0000); chk("R3 rts low", rts, 0);

    for (int i = 0; i < 6; i++) begin
      c = VEC[i][10:8];
      bw(0, 32'h80 | c);
      bw(1, 32'hABCD_EF00 | VEC[i][7:0]);
      idle(12 * (4 << c) + 20);
      br(0, d); chk("R8 status after rx", d, 32'hF8);
      br(1, d); chk("R2 R5 loopback data", d, {24'h0, VEC[i][7:0]});
    end
    br(0, d); chk("R8 status after read", d, 32'hD0);

    for (int k = 0; k < 3; k++) begin
      c = (k == 0) ? 3'd0 : (k == 1) ? 3'd3 : 3'd7;
      bw(0, 32'h80 | c); idle(2);
      bw(1, 32'h01);
      w = 0;
      while (txd && w < 100) begin @(negedge clk); w++; end
      n = 0;
      while (!txd && n < 1000) begin n++; @(negedge clk); end
      chk("R4 bit period", n, (c == 3'd7) ? 256 : (4 << c));
      idle(12 * ((c == 3'd7) ? 256 : (4 << c)) + 20);
      br(1, d);
    end

    bw(0, 32'h80); idle(2);
    bw(1, 32'h4B);
    w = 0;
    while (txd && w < 100) begin @(negedge clk); w++; end
    idle(2);
    for (int i = 0; i < 10; i++) begin cap[i] = txd; idle(4); end
    chk("R5 frame bits", cap, {1'b1, 8'h4B, 1'b0});
    idle(40); br(1, d);

    cts = 0; idle(4);
    bw(1, 32'h77); idle(100);
    chk("R6 txd held", txd, 1);
    br(0, d); chk("R6 status cts low", d, 32'h00);
    cts = 1; idle(80);
    br(1, d); chk("R6 char after cts", d, 32'h77);

    bw(0, 32'h90); idle(3);
    chk("R12 tx irq", irq, 1);
    cts = 0; idle(4);
    bw(1, 32'h5A); idle(3);
    chk("R7 irq cleared", irq, 0);
    br(0, d); chk("R7 status after write", d, 32'h00);
    cts = 1; idle(10);
    chk("R7 irq after transfer", irq, 1);
    br(0, d); chk("R7 status after transfer", d, 32'hD0);
    idle(60); br(1, d); chk("R8 data", d, 32'h5A);

    bw(0, 32'h88); idle(3);
    chk("R12 masked tx pend", irq, 0);
    bw(1, 32'h3E); idle(70);
    chk("R12 rx irq", irq, 1);
    br(1, d); chk("R8 rx data", d, 32'h3E);
    idle(3); chk("R12 rx irq cleared", irq, 0);

    bw(0, 32'h80);
    bw(1, 32'h11); idle(70);
    bw(1, 32'h22); idle(70);
    br(0, d); chk("R10 overrun status", d, 32'hF9);
    br(1, d); chk("R10 newest kept", d, 32'h22);
    br(0, d); chk("R11 overrun cleared", d, 32'hD0);

    use_brx = 1; idle(10);
    send_raw(8'hC6, 1'b0);
    br(0, d); chk("R9 framing status", d, 32'hFA);
    br(1, d); chk("R9 data kept", d, 32'hC6);
    br(0, d); chk("R11 framing cleared", d, 32'hD0);
    send_raw(8'h69, 1'b1);
    br(0, d); chk("R9 good stop", d, 32'hF8);
    br(1, d); chk("R9 good data", d, 32'h69);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule